// File: doc/BRIEF.md
# Dual-Slope Frequency-Correct PWM Timer

This block is a 16-bit up/down timer that generates centre-aligned PWM. The counter climbs from 0 to a TOP value and falls back to 0, and it repeats this without pause. Each of the two output channels compares the count with its own compare value. A match on the rising slope moves the output one way and a match on the falling slope moves it back. Compare values are double-buffered and take effect only when the count is at 0. Every period is therefore symmetrical, and changing the duty cycle or TOP never produces a short or torn pulse.

TOP comes from one of two places. The first is channel 0's buffered compare value, which suits a period that software changes on the fly. The second is a separate fixed register, which leaves channel 0 free to drive a PWM output. A prescaler sets the step rate.

Register access is reduced to single-cycle write strobes. There is no data stream, so there is no valid/ready handshake and no back-pressure. A write is taken on the clock edge on which its strobe is high. Every other pin is plain control or status.

Top module: `pfc_pwm_timer`

## Requirements
- R1: While `rst_n` is low, `count`, every `pwm_out` bit and every event output are 0. After release the counter starts at 0 and counts up.
- R2: On each tick the count moves by exactly one. It rises from 0 until it equals TOP, then falls back to 0, and it turns at both ends without repeating a value, so a period is 2·TOP ticks. With a TOP of 0 the count steps down to 0 and stays there.
- R3: `clk_sel` sets the tick rate from a free-running divider that reset clears. Codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 give no ticks, and the count holds.
- R4: A compare write goes into a shadow register. The active compare value copies the shadow only on a tick where the count is 0. `ovf_evt` marks exactly those ticks.
- R5: With `top_src` = 0, TOP is the fixed register written through `cap_we`, which takes effect immediately, and `top_evt` marks the tick where the count equals TOP. With `top_src` = 1, TOP is channel 0's active compare value, `top_evt` stays low, and `cmp_evt[0]` marks TOP.
- R6: Mode 2 selects non-inverted PWM. Channel i takes its mode from `com_mode[2i+1:2i]`. A match on a rising step clears the output and a match on a falling step sets it. The step away from TOP counts as falling and the step away from 0 counts as rising. As a result, compare C gives 2·C high ticks per period: C = 0 keeps the output low, and C = TOP keeps it high once TOP has been reached.
- R7: Mode 3 selects inverted PWM, with the set and clear actions of mode 2 swapped. Compare 0 therefore keeps the output high and compare TOP keeps it low.
- R8: Mode 1 toggles the output on every match. When channel 0 also defines TOP, output 0 is a 50 % square wave with a period of 4·TOP ticks.
- R9: Mode 0 disconnects the channel, and its output reads 0.
- R10: A compare value above TOP never matches. That channel's `cmp_evt` stays low and its output keeps its level.
- R11: `cmp_evt[i]` marks a tick on which the count equals channel i's active compare value. All event outputs are registered one-clock pulses that appear only after ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 3 | Prescaler code (0, 6, 7 stop; 1..5 divide by 1, 8, 64, 256, 1024) |
| top_src | input | 1 | 0: TOP from fixed register; 1: TOP from channel 0 compare |
| cmp_we | input | NCH | Per-channel compare shadow write strobe |
| cmp_wdata | input | W | Compare write data |
| cap_we | input | 1 | Fixed TOP register write strobe |
| cap_wdata | input | W | Fixed TOP write data |
| com_mode | input | 2·NCH | Output mode, two bits per channel |
| count | output | W | Current counter value |
| pwm_out | output | NCH | Waveform outputs |
| ovf_evt | output | 1 | Pulse after a tick at 0 |
| top_evt | output | 1 | Pulse after a tick at TOP (fixed-register source) |
| cmp_evt | output | NCH | Per-channel match pulse |

## Verification
The count, the event pulses and the waveform registers all update on the clock edge that carries a tick. They are visible one clock later, alongside the next count value. The one exception is a channel switched to mode 0, whose output drops within the same cycle. Before each edge the bench computes what that edge should produce and queues it. A monitor pops one entry one nanosecond after every rising edge and compares it with the outputs, so every comparison falls in the cycle in which its result is due. Windowed counts over whole periods then confirm duty cycles, event rates and prescaler intervals.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Largest divisor is 2**DIV_LOG2_MAX clocks per tick.
  localparam int DIV_LOG2_MAX = 10;

  typedef enum logic [1:0] {
    OM_OFF     = 2'd0,
    OM_TOGGLE  = 2'd1,
    OM_PWM     = 2'd2,
    OM_PWM_INV = 2'd3
  } out_mode_e;

  // Low-bit mask of the free-running divider that must be all ones for a tick.
  function automatic logic [DIV_LOG2_MAX-1:0] div_mask(input logic [2:0] sel);
    case (sel)
      3'd2:    return DIV_LOG2_MAX'(7);
      3'd3:    return DIV_LOG2_MAX'(63);
      3'd4:    return DIV_LOG2_MAX'(255);
      3'd5:    return DIV_LOG2_MAX'(1023);
      default: return '0;
    endcase
  endfunction

  function automatic logic div_run(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

endpackage

// File: rtl/pfc_prescale.sv
module pfc_prescale
  import pfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [DIV_LOG2_MAX-1:0] div_q;
  logic [DIV_LOG2_MAX-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    mask = div_mask(sel);
    tick = div_run(sel) && ((div_q & mask) == mask);
  end
endmodule

// File: rtl/pfc_counter.sv
module pfc_counter #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    top_src,
  input  logic [NCH-1:0]          cmp_we,
  input  logic [W-1:0]            cmp_wdata,
  input  logic                    cap_we,
  input  logic [W-1:0]            cap_wdata,
  output logic [W-1:0]            cnt_q,
  output logic                    step_up,
  output logic                    at_bottom,
  output logic                    top_hit,
  output logic [NCH-1:0][W-1:0]   eff_cmp
);
  logic [NCH-1:0][W-1:0] shad_q;
  logic [NCH-1:0][W-1:0] act_q;
  logic [W-1:0]          cap_q;
  logic [W-1:0]          top_val;
  logic                  up_q;
  logic                  past_top;
  logic                  parked;

  always_comb begin
    at_bottom = (cnt_q == '0);
    for (int i = 0; i < NCH; i++) begin
      // At BOTTOM the value about to be loaded governs the coming period.
      eff_cmp[i] = at_bottom ? shad_q[i] : act_q[i];
    end
    top_val  = top_src ? eff_cmp[0] : cap_q;
    past_top = (cnt_q >= top_val);
    top_hit  = (cnt_q == top_val);
    step_up  = at_bottom || (up_q && !past_top);
    parked   = at_bottom && (top_val == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q <= '0;
      act_q  <= '0;
      cap_q  <= '0;
      cnt_q  <= '0;
      up_q   <= 1'b1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (cmp_we[i]) shad_q[i] <= cmp_wdata;
      end
      if (cap_we) cap_q <= cap_wdata;
      if (tick) begin
        up_q <= step_up;
        if (!parked) cnt_q <= step_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        if (at_bottom) act_q <= shad_q;
      end
    end
  end
endmodule

// File: rtl/pfc_wave.sv
module pfc_wave
  import pfc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         step_up,
  input  logic [1:0]   mode,
  output logic         pwm,
  output logic         hit_evt
);
  out_mode_e mode_e;
  logic      hit;
  logic      oc_q;

  always_comb begin
    mode_e = out_mode_e'(mode);
    hit    = tick && (cnt == cmp);
    pwm    = (mode_e == OM_OFF) ? 1'b0 : oc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q    <= 1'b0;
      hit_evt <= 1'b0;
    end else begin
      hit_evt <= hit;
      if (hit) begin
        case (mode_e)
          OM_TOGGLE:  oc_q <= ~oc_q;
          OM_PWM:     oc_q <= ~step_up;
          OM_PWM_INV: oc_q <= step_up;
          default:    oc_q <= oc_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/pfc_pwm_timer.sv
module pfc_pwm_timer #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic             top_src,
  input  logic [NCH-1:0]   cmp_we,
  input  logic [W-1:0]     cmp_wdata,
  input  logic             cap_we,
  input  logic [W-1:0]     cap_wdata,
  input  logic [2*NCH-1:0] com_mode,
  output logic [W-1:0]     count,
  output logic [NCH-1:0]   pwm_out,
  output logic             ovf_evt,
  output logic             top_evt,
  output logic [NCH-1:0]   cmp_evt
);
  logic                  tick;
  logic                  step_up;
  logic                  at_bottom;
  logic                  top_hit;
  logic [NCH-1:0][W-1:0] eff_cmp;

  pfc_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (clk_sel),
    .tick (tick)
  );

  pfc_counter #(.W(W), .NCH(NCH)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .top_src  (top_src),
    .cmp_we   (cmp_we),
    .cmp_wdata(cmp_wdata),
    .cap_we   (cap_we),
    .cap_wdata(cap_wdata),
    .cnt_q    (count),
    .step_up  (step_up),
    .at_bottom(at_bottom),
    .top_hit  (top_hit),
    .eff_cmp  (eff_cmp)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfc_wave #(.W(W)) u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt    (count),
      .cmp    (eff_cmp[g]),
      .step_up(step_up),
      .mode   (com_mode[2*g +: 2]),
      .pwm    (pwm_out[g]),
      .hit_evt(cmp_evt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_evt <= 1'b0;
      top_evt <= 1'b0;
    end else begin
      ovf_evt <= tick && at_bottom;
      top_evt <= tick && top_hit && !top_src;
    end
  end
endmodule

// File: rtl/pfc_pwm_timer_chk.sv
module pfc_pwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   clk_sel,
  input logic         top_src,
  input logic [W-1:0] count,
  input logic         ovf_evt,
  input logic         top_evt
);
  // R2: the count never jumps by more than one step
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |->
      ((W'(count - $past(count)) == W'(1)) || (W'($past(count) - count) == W'(1))));

  // R3: a stopped prescaler leaves the count untouched
  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |=> $stable(count));

  // R4: the overflow pulse accompanies the step away from 0
  a_r4_ovf_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> (count <= W'(1)));

  // R5: no TOP pulse while channel 0 defines TOP
  a_r5_no_top_from_a: assert property (@(posedge clk) disable iff (!rst_n)
    top_src |=> !top_evt);

  // R11: event pulses only follow a running prescaler
  a_r11_evt_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt || top_evt) |-> (($past(clk_sel) >= 3'd1) && ($past(clk_sel) <= 3'd5)));
endmodule

bind pfc_pwm_timer pfc_pwm_timer_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clk_sel(clk_sel),
  .top_src(top_src),
  .count  (count),
  .ovf_evt(ovf_evt),
  .top_evt(top_evt)
);

// File: tb/pfc_pwm_timer_bench.sv
`timescale 1ns/1ps
module pfc_pwm_timer_bench;
  localparam int W   = 16;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [2:0]       clk_sel;
  logic             top_src;
  logic [NCH-1:0]   cmp_we;
  logic [W-1:0]     cmp_wdata;
  logic             cap_we;
  logic [W-1:0]     cap_wdata;
  logic [2*NCH-1:0] com_mode;
  logic [W-1:0]     count;
  logic [NCH-1:0]   pwm_out;
  logic             ovf_evt;
  logic             top_evt;
  logic [NCH-1:0]   cmp_evt;

  pfc_pwm_timer #(.W(W), .NCH(NCH)) u_pfc_pwm_timer (.*);

  typedef struct {
    int       cnt;
    bit       ovf;
    bit       top;
    bit [1:0] hit;
    bit [1:0] pwm;
    int       md [2];
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int total = 0;
  int bad   = 0;

  // reference state
  int k, mcnt, mcap;
  bit mup;
  int mshad [2];
  int mact  [2];
  bit moc   [2];

  // window statistics
  int hi [2];
  int hitn [2];
  int ovfn, topn, maxc;

  function automatic int divisor(logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected outputs after the coming edge, from the requirements.
  task automatic model_step();
    exp_t e;
    int n = divisor(clk_sel);
    bit tk = (n != 0) && ((k % n) == n - 1);
    bit bot = (mcnt == 0);
    int eff [2];
    int tp;
    bit up;
    k++;
    for (int i = 0; i < 2; i++) eff[i] = bot ? mshad[i] : mact[i];
    tp = top_src ? eff[0] : mcap;
    up = bot || (mup && (mcnt < tp));
    e.ovf = tk && bot;
    e.top = tk && !top_src && (mcnt == tp);
    for (int i = 0; i < 2; i++) begin
      e.md[i]  = int'(com_mode[2*i +: 2]);
      e.hit[i] = tk && (mcnt == eff[i]);
      if (e.hit[i]) begin
        case (e.md[i])
          1: moc[i] = !moc[i];
          2: moc[i] = !up;
          3: moc[i] = up;
          default: ;
        endcase
      end
    end
    if (tk) begin
      mup = up;
      if (!(bot && tp == 0)) mcnt = up ? (mcnt + 1) % 65536 : mcnt - 1;
      if (bot) for (int i = 0; i < 2; i++) mact[i] = mshad[i];
    end
    for (int i = 0; i < 2; i++) if (cmp_we[i]) mshad[i] = int'(cmp_wdata);
    if (cap_we) mcap = int'(cap_wdata);
    e.cnt = mcnt;
    for (int i = 0; i < 2; i++) e.pwm[i] = (e.md[i] == 0) ? 1'b0 : moc[i];
    q.push_back(e);
  endtask

  function automatic string mode_tag(int md);
    case (md)
      0: return "R9 pwm off";
      1: return "R8 pwm toggle";
      2: return "R6 pwm non-inverted (compare from BOTTOM load, R4)";
      default: return "R7 pwm inverted";
    endcase
  endfunction

  // monitor: one expected item per clock, compared just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      check("R2 count", int'(count), cur.cnt);
      check("R4 ovf_evt", int'(ovf_evt), int'(cur.ovf));
      check("R5 top_evt", int'(top_evt), int'(cur.top));
      for (int i = 0; i < 2; i++) begin
        check("R11 cmp_evt", int'(cmp_evt[i]), int'(cur.hit[i]));
        check(mode_tag(cur.md[i]), int'(pwm_out[i]), int'(cur.pwm[i]));
        hi[i]   += int'(pwm_out[i]);
        hitn[i] += int'(cmp_evt[i]);
      end
      ovfn += int'(ovf_evt);
      topn += int'(top_evt);
      if (int'(count) > maxc) maxc = int'(count);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_cmp(int i, int v);
    cmp_we[i] = 1'b1;
    cmp_wdata = W'(v);
    cyc();
    cmp_we = '0;
  endtask

  task automatic wr_cap(int v);
    cap_we    = 1'b1;
    cap_wdata = W'(v);
    cyc();
    cap_we = 1'b0;
  endtask

  task automatic window(int n);
    for (int i = 0; i < 2; i++) begin hi[i] = 0; hitn[i] = 0; end
    ovfn = 0; topn = 0; maxc = 0;
    cyc(n);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int old, n;
    rst_n = 1'b0; clk_sel = 3'd0; top_src = 1'b0; cmp_we = '0; cmp_wdata = '0;
    cap_we = 1'b0; cap_wdata = '0; com_mode = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    check("R1 pwm in reset", int'(pwm_out), 0);
    check("R1 events in reset", int'({ovf_evt, top_evt, cmp_evt}), 0);
    rst_n = 1'b1;
    k = 0; mcnt = 0; mup = 1'b1; mcap = 0;
    for (int i = 0; i < 2; i++) begin mshad[i] = 0; mact[i] = 0; moc[i] = 1'b0; end

    // Basic run: TOP 10 from fixed register, A mode 2 at 4, B mode 3 at 7
    clk_sel  = 3'd1;
    com_mode = {2'd3, 2'd2};
    wr_cap(10);
    wr_cmp(0, 4);
    wr_cmp(1, 7);
    cyc(45);
    window(20);
    check("R6 high ticks compare 4 top 10", hi[0], 8);
    check("R7 high ticks compare 7 top 10", hi[1], 6);
    check("R4 one overflow per period", ovfn, 1);
    check("R5 one top event per period", topn, 1);
    check("R2 peak equals TOP", maxc, 10);
    check("R11 two matches per period", hitn[0], 2);

    // Mid-period compare change, taken at the next BOTTOM (scoreboard)
    cyc(3);
    wr_cmp(0, 2);
    cyc(40);

    // Extremes, non-inverted
    wr_cmp(0, 0);
    wr_cmp(1, 10);
    com_mode = {2'd2, 2'd2};
    cyc(45);
    window(20);
    check("R6 compare at BOTTOM stays low", hi[0], 0);
    check("R6 compare at TOP stays high", hi[1], 20);

    // Extremes, inverted
    com_mode = {2'd3, 2'd3};
    cyc(25);
    window(20);
    check("R7 compare at BOTTOM stays high", hi[0], 20);
    check("R7 compare at TOP stays low", hi[1], 0);

    // Compare above TOP, and disconnected channel
    wr_cmp(0, 15);
    com_mode = {2'd0, 2'd2};
    cyc(45);
    window(20);
    check("R10 no match above TOP", hitn[0], 0);
    check("R10 output keeps level", hi[0], 20);
    check("R9 mode 0 output low", hi[1], 0);

    // TOP from channel 0 with toggle output
    top_src  = 1'b1;
    com_mode = {2'd0, 2'd1};
    wr_cmp(0, 6);
    cyc(100);
    window(24);
    check("R8 toggle gives 50 percent", hi[0], 12);
    check("R5 no top_evt when channel 0 defines TOP", topn, 0);
    check("R5 cmp_evt[0] at TOP", hitn[0], 2);
    check("R2 peak equals channel 0 TOP", maxc, 6);

    // Prescaler divisors
    top_src = 1'b0;
    wr_cap(3);
    for (int s = 2; s <= 5; s++) begin
      clk_sel = 3'(s);
      old = int'(count);
      n = 0;
      while (int'(count) == old && n < 2100) begin cyc(); n++; end
      old = int'(count);
      n = 0;
      while (int'(count) == old && n < 2100) begin cyc(); n++; end
      check("R3 clocks per step", n, divisor(3'(s)));
    end

    // Stopped prescaler codes
    foreach (clk_sel[b]) begin end
    clk_sel = 3'd0;
    cyc(2);
    old = int'(count);
    window(50);
    check("R3 code 0 holds count", int'(count), old);
    check("R11 no events while stopped", ovfn + topn + hitn[0] + hitn[1], 0);
    clk_sel = 3'd7;
    window(30);
    check("R3 code 7 holds count", int'(count), old);

    // TOP of zero parks the counter at 0
    clk_sel = 3'd1;
    wr_cap(0);
    cyc(20);
    window(10);
    check("R2 TOP zero parks at 0", maxc, 0);

    finish_run();
  end
endmodule